// File: doc/BRIEF.md
# Real-Time Clock Register Block

This block keeps a 32-bit seconds counter behind a small register window on a 32-bit, word-only, little-endian bus (bit 0 of every register is the least significant bit of its lowest byte). A prescaler of configurable length divides the block clock into seconds. Software loads the counter through a load register. It reads the live count back from that register or from a dedicated time register. The prescaler value shows up as a sub-second tick field. The block also holds an alarm compare register, a fixed calibration readback and a control word.

The block has two interrupt groups. The timer group has two sources: a seconds tick and an alarm match. The error group has one source: an access to an offset that no register decodes. Each group has a write-one-to-clear status register and a mask that the bus cannot write directly. Writing ones to the group's enable register clears mask bits, and writing ones to its disable register sets them. Each group drives its own level interrupt output.

A request is one cycle of `req_i`, which is a write when `we_i` is high. Read data comes back one cycle later, together with `rvalid_o`.

Top module: `rtc_regblk`

## Requirements
- R1: After reset both interrupt outputs are low, the timer mask (offset 9) reads 0x3, the error mask (offset 13) reads 0x1, both status registers (offsets 8 and 12) read 0, the alarm (offset 4) reads 0 and the control word (offset 5) reads 0x0100_0000.
- R2: A write to offset 1 loads the seconds counter and restarts the prescaler at zero. Reads of offset 0 and of offset 1 both return the live seconds count.
- R3: The seconds count rises by one each time the prescaler completes PRESC_DIV clocks. Offset 2 returns the prescaler in bits 15:0, always below PRESC_DIV, with the upper bits zero.
- R4: Offset 4 holds a read/write alarm value. Timer status bit 0 is set on every seconds increment. Timer status bit 1 is set on the increment that makes the count equal the alarm.
- R5: The status registers (timer at offset 8, bits 1:0; error at offset 12, bit 0) clear each bit written as one. Bits written as zero keep their value.
- R6: Writes to the mask registers (offsets 9 and 13) have no effect.
- R7: Writing to offset 10 (timer) or 14 (error) clears the mask bits that are one in the data. Writing to offset 11 or 15 sets those mask bits. All four of these registers read as 0.
- R8: `rtc_irq_o` is high exactly when some timer status bit is set and its mask bit is clear. `err_irq_o` follows the same rule for the error group.
- R9: A read or write to any offset other than 0–5 and 8–15 sets error status bit 0. A read of such an offset returns 0.
- R10: Control bits in mask 0x70FF_FFFE ignore writes and read as 0. The other control bits are read/write.
- R11: Offset 3 returns CALIB_VAL limited to its low 21 bits. Writes to offset 3 have no effect.
- R12: `rvalid_o` pulses for exactly one cycle, in the cycle after each read request and after no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | High for write, low for read |
| addr_i | input | AW | Word offset |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| rtc_irq_o | output | 1 | Timer interrupt, level |
| err_irq_o | output | 1 | Address-error interrupt, level |

## Verification
The bench drives each mask only through its enable and disable registers. A design that let the bus write the mask directly would show a changed mask readback, and one that swapped the set and clear rules would raise or drop the interrupt line on the wrong write. The bench also writes zero to a status register: a design that cleared on any write would lose the pending bit. A design that raised the alarm on the wrong count would show status bit 1 missing at the expected second. Unmapped reads and writes must both set the error bit and read zero. A decoder that confused an unmapped offset with a real one would leave the error interrupt low after it was enabled.

// File: rtl/rtc_regblk_pkg.sv
package rtc_regblk_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SEC_W   = 32;
  localparam int unsigned TICK_W  = 16;
  localparam int unsigned CALIB_W = 21;
  localparam int unsigned RTC_SRC = 2;
  localparam int unsigned ERR_SRC = 1;

  localparam int unsigned OFS_TIME_NOW  = 0;
  localparam int unsigned OFS_TIME_LOAD = 1;
  localparam int unsigned OFS_TICK      = 2;
  localparam int unsigned OFS_CALIB     = 3;
  localparam int unsigned OFS_ALARM     = 4;
  localparam int unsigned OFS_CTRL      = 5;
  localparam int unsigned OFS_RTC_STAT  = 8;
  localparam int unsigned OFS_RTC_MASK  = 9;
  localparam int unsigned OFS_RTC_EN    = 10;
  localparam int unsigned OFS_RTC_DIS   = 11;
  localparam int unsigned OFS_ERR_STAT  = 12;
  localparam int unsigned OFS_ERR_MASK  = 13;
  localparam int unsigned OFS_ERR_EN    = 14;
  localparam int unsigned OFS_ERR_DIS   = 15;

  localparam logic [DATA_W-1:0] CTRL_RST   = 32'h0100_0000;
  localparam logic [DATA_W-1:0] CTRL_RSVD  = 32'h70FF_FFFE;
  localparam logic [DATA_W-1:0] CTRL_WMASK = ~CTRL_RSVD;

  typedef struct packed {
    logic set_load;
    logic alarm_wr;
    logic ctrl_wr;
    logic rtc_stat_wr;
    logic rtc_en_wr;
    logic rtc_dis_wr;
    logic err_stat_wr;
    logic err_en_wr;
    logic err_dis_wr;
  } wr_sel_t;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned PRESC_DIV = 32768,
  parameter int unsigned SEC_W     = 32,
  parameter int unsigned TICK_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  load_val_i,
  input  logic [SEC_W-1:0]  alarm_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              inc_o,
  output logic              alarm_hit_o
);
  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0]    pre_q;
  logic [SEC_W-1:0] sec_q;
  logic             wrap;

  assign wrap        = (pre_q == PRE_LAST);
  assign inc_o       = wrap && !load_i;
  assign alarm_hit_o = inc_o && ((sec_q + SEC_W'(1)) == alarm_i);
  assign sec_o       = sec_q;
  assign tick_o      = TICK_W'(pre_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sec_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      sec_q <= load_val_i;
    end else if (wrap) begin
      pre_q <= '0;
      sec_q <= sec_q + SEC_W'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  assert_load_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_o == $past(load_val_i) && tick_o == '0));

  assert_tick_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tick_o) < PRESC_DIV);

  assert_sec_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_o != TICK_W'(PRESC_DIV - 1)) |=> $stable(sec_o));
endmodule

// File: rtl/rtc_irq_group.sv
module rtc_irq_group #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] dis_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      // a new event in the same cycle as its clear is kept
      stat_q <= (stat_q & ~clr_i) | set_i;
      mask_q <= (mask_q & ~en_i) | dis_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);

  assert_w1c_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0));

  assert_set_sticks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

  assert_en_clears_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i != '0 && dis_i == '0) |=> ((mask_o & $past(en_i)) == '0));

  assert_dis_sets_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i != '0) |=> ((mask_o & $past(dis_i)) == $past(dis_i)));

  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0 && dis_i == '0) |=> $stable(mask_o));
endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
  import rtc_regblk_pkg::*;
#(
  parameter int unsigned AW        = 6,
  parameter int unsigned PRESC_DIV = 32768,
  parameter logic [31:0] CALIB_VAL = 32'h0000_7FFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          rvalid_o,
  output logic [31:0]   rdata_o,
  output logic          rtc_irq_o,
  output logic          err_irq_o
);
  localparam logic [31:0] CALIB_RD = CALIB_VAL & ((32'h1 << CALIB_W) - 32'h1);

  logic [SEC_W-1:0]   sec;
  logic [TICK_W-1:0]  tick;
  logic               sec_inc, alarm_hit;
  logic [31:0]        alarm_q, ctrl_q;
  logic [RTC_SRC-1:0] rtc_stat, rtc_mask;
  logic [ERR_SRC-1:0] err_stat, err_mask;
  logic               hit, wr, rd;
  logic [31:0]        rd_mux;
  wr_sel_t            ws;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  always_comb begin
    hit    = 1'b1;
    rd_mux = '0;
    ws     = '0;
    unique case (addr_i)
      AW'(OFS_TIME_NOW):  rd_mux = sec;
      AW'(OFS_TIME_LOAD): begin rd_mux = sec; ws.set_load = wr; end
      AW'(OFS_TICK):      rd_mux = 32'(tick);
      AW'(OFS_CALIB):     rd_mux = CALIB_RD;
      AW'(OFS_ALARM):     begin rd_mux = alarm_q; ws.alarm_wr = wr; end
      AW'(OFS_CTRL):      begin rd_mux = ctrl_q; ws.ctrl_wr = wr; end
      AW'(OFS_RTC_STAT):  begin rd_mux = 32'(rtc_stat); ws.rtc_stat_wr = wr; end
      AW'(OFS_RTC_MASK):  rd_mux = 32'(rtc_mask);
      AW'(OFS_RTC_EN):    ws.rtc_en_wr = wr;
      AW'(OFS_RTC_DIS):   ws.rtc_dis_wr = wr;
      AW'(OFS_ERR_STAT):  begin rd_mux = 32'(err_stat); ws.err_stat_wr = wr; end
      AW'(OFS_ERR_MASK):  rd_mux = 32'(err_mask);
      AW'(OFS_ERR_EN):    ws.err_en_wr = wr;
      AW'(OFS_ERR_DIS):   ws.err_dis_wr = wr;
      default:            hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q  <= '0;
      ctrl_q   <= CTRL_RST;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (ws.alarm_wr) alarm_q <= wdata_i;
      if (ws.ctrl_wr)  ctrl_q  <= wdata_i & CTRL_WMASK;
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  rtc_sec_counter #(
    .PRESC_DIV(PRESC_DIV),
    .SEC_W    (SEC_W),
    .TICK_W   (TICK_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ws.set_load),
    .load_val_i (wdata_i),
    .alarm_i    (alarm_q),
    .sec_o      (sec),
    .tick_o     (tick),
    .inc_o      (sec_inc),
    .alarm_hit_o(alarm_hit)
  );

  rtc_irq_group #(.W(RTC_SRC)) u_rtc_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i ({alarm_hit, sec_inc}),
    .clr_i (ws.rtc_stat_wr ? wdata_i[RTC_SRC-1:0] : '0),
    .en_i  (ws.rtc_en_wr   ? wdata_i[RTC_SRC-1:0] : '0),
    .dis_i (ws.rtc_dis_wr  ? wdata_i[RTC_SRC-1:0] : '0),
    .stat_o(rtc_stat),
    .mask_o(rtc_mask),
    .irq_o (rtc_irq_o)
  );

  rtc_irq_group #(.W(ERR_SRC)) u_err_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (req_i && !hit),
    .clr_i (ws.err_stat_wr ? wdata_i[ERR_SRC-1:0] : '0),
    .en_i  (ws.err_en_wr   ? wdata_i[ERR_SRC-1:0] : '0),
    .dis_i (ws.err_dis_wr  ? wdata_i[ERR_SRC-1:0] : '0),
    .stat_o(err_stat),
    .mask_o(err_mask),
    .irq_o (err_irq_o)
  );

  assert_unmapped_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |=> err_stat[0]);

  assert_rvalid_follows_read_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);

  assert_no_rvalid_on_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);

  assert_ctrl_rsvd_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr_i) == AW'(OFS_CTRL)) |-> ((rdata_o & CTRL_RSVD) == '0));
endmodule

// File: tb/rtc_regblk_tb.sv
module rtc_regblk_tb;
  localparam int unsigned AW   = 6;
  localparam int unsigned DIV  = 64;
  localparam logic [31:0] CAL  = 32'hFFF2_3456;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic rvalid_o, rtc_irq_o, err_irq_o;

  int n_tests = 0, n_fail = 0, n_reads = 0, n_rvalid = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; logic [31:0] msk; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  rtc_regblk #(.AW(AW), .PRESC_DIV(DIV), .CALIB_VAL(CAL)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .rtc_irq_o(rtc_irq_o), .err_irq_o(err_irq_o)
  );

  // monitor: compare each returned word against the oldest expectation
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      n_rvalid++;
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected rvalid: actual %h expected none", rdata_o);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if ((rdata_o & it.msk) != (it.exp & it.msk)) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h (mask %h)", it.tag, rdata_o, it.exp, it.msk);
        end
      end
    end
  end

  task automatic rd(input int a, input logic [31:0] e, input string tag,
                    input logic [31:0] m = 32'hFFFF_FFFF);
    item_t it;
    it.exp = e; it.msk = m; it.tag = tag;
    @(negedge clk_i);
    sb_q.push_back(it);
    n_reads++;
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(a);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset values
    chk(rtc_irq_o, 1'b0, "R1 rtc_irq reset");
    chk(err_irq_o, 1'b0, "R1 err_irq reset");
    rd(9,  32'h3, "R1 timer mask");
    rd(13, 32'h1, "R1 error mask");
    rd(8,  32'h0, "R1 timer status");
    rd(12, 32'h0, "R1 error status");
    rd(5,  32'h0100_0000, "R1 control");
    rd(4,  32'h0, "R1 alarm");

    // R10 control reserved bits
    wr(5, 32'hFFFF_FFFF);
    rd(5, 32'h8F00_0001, "R10 control all ones");
    wr(5, 32'h0);
    rd(5, 32'h0, "R10 control zero");

    // R11 calibration readback
    rd(3, 32'h0012_3456, "R11 calib");
    wr(3, 32'h0);
    rd(3, 32'h0012_3456, "R11 calib write ignored");

    // R6 mask not writable
    wr(9, 32'h0);
    wr(13, 32'h0);
    rd(9,  32'h3, "R6 timer mask write ignored");
    rd(13, 32'h1, "R6 error mask write ignored");

    // R2 / R3 / R4 load and count
    wr(4, 32'hFFFF_FFF0);
    rd(4, 32'hFFFF_FFF0, "R4 alarm readback");
    wr(1, 32'd100);
    rd(0, 32'd100, "R2 time now after load");
    rd(1, 32'd100, "R2 load readback");
    rd(2, 32'h0, "R3 tick below divider", 32'hFFFF_FFC0);
    idle(64);
    rd(0, 32'd101, "R3 one second later");
    rd(8, 32'h1, "R4 status bit0 after increment");
    chk(rtc_irq_o, 1'b0, "R8 masked source");

    // R7 / R8 enable
    wr(10, 32'h1);
    rd(9, 32'h2, "R7 enable clears bit0");
    rd(10, 32'h0, "R7 enable reads zero");
    chk(rtc_irq_o, 1'b1, "R8 unmasked pending");

    // R5 write-one-to-clear
    wr(1, 32'd500);
    wr(8, 32'h0);
    rd(8, 32'h1, "R5 zero write keeps status");
    wr(8, 32'h1);
    chk(rtc_irq_o, 1'b0, "R8 cleared status");
    rd(8, 32'h0, "R5 status cleared");

    // R7 disable
    wr(11, 32'h1);
    rd(9, 32'h3, "R7 disable sets bit0");
    rd(11, 32'h0, "R7 disable reads zero");
    idle(70);
    rd(8, 32'h1, "R4 status bit0 while masked");
    chk(rtc_irq_o, 1'b0, "R8 masked after disable");

    // R4 alarm match
    wr(8, 32'h3);
    wr(4, 32'd602);
    wr(10, 32'h2);
    rd(9, 32'h1, "R7 enable clears bit1");
    wr(1, 32'd600);
    idle(140);
    rd(0, 32'd602, "R3 two seconds later");
    rd(8, 32'h3, "R4 alarm status bit1");
    chk(rtc_irq_o, 1'b1, "R8 alarm irq");

    // R9 error group
    rd(12, 32'h0, "R9 error status before");
    rd(7, 32'h0, "R9 unmapped read zero");
    rd(12, 32'h1, "R9 error status after read");
    chk(err_irq_o, 1'b0, "R8 error masked");
    wr(14, 32'h1);
    chk(err_irq_o, 1'b1, "R8 error enabled");
    rd(13, 32'h0, "R7 error enable");
    wr(12, 32'h1);
    chk(err_irq_o, 1'b0, "R5 error cleared irq");
    rd(12, 32'h0, "R5 error status cleared");
    wr(40, 32'hDEAD_BEEF);
    chk(err_irq_o, 1'b1, "R9 unmapped write flags");
    wr(15, 32'h1);
    chk(err_irq_o, 1'b0, "R7 error disable");
    rd(13, 32'h1, "R7 error mask set");

    idle(3);
    // R12 one response per read
    n_tests++;
    if (n_rvalid != n_reads || sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 responses: actual %0d expected %0d", n_rvalid, n_reads);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule